// File: doc/BRIEF.md
# Byte-Wide PCS Transmit Code-Group Sequencer

This block produces the octet stream, with a control-character flag, that feeds the transmit side of a byte-wide PCS encoder. While no frame is waiting it repeats an idle pair made of a comma control character and a data character. When software-side logic has placed a frame in the transmit FIFO and pulses a start request, the sequencer waits for the current idle pair to finish. It then sends a start-of-packet control character, the preamble octets and the start-of-frame delimiter, followed by the frame bytes pulled from the FIFO.

The FIFO has one cycle of read latency, and the block registers every code group it emits. For that reason the read strobe rises two cycles before the first frame byte has to appear. The FIFO marks the final byte with a last-byte flag, an empty flag, or both. The read strobe stays high during that byte's cycle and falls one cycle later, so exactly one extra read is issued and its result is discarded. The frame ends with a terminate control character and a carrier-extend control character. If the extend character falls on an even position of the code-group stream, a second one is sent, so the next idle pair starts on an even position.

Top module: `sgx_tx_seq`

## Requirements
- R1: During reset and in the first cycle after it, tx_data is 0xBC with tx_k = 1 and tx_fifo_re = 0.
- R2: With no frame pending, the output repeats the pair 0xBC with tx_k = 1 followed by 0x50 with tx_k = 0, and tx_fifo_re stays 0.
- R3: A one-cycle tx_start pulse is remembered until it is served. The frame opens with 0xFB (tx_k = 1) on the cycle right after a 0x50 idle octet, which is an even position counted from position 0 just after reset. It never opens between 0xBC and 0x50.
- R4: After 0xFB come PRE_LEN octets of PRE_BYTE (default 6 of 0x55) and then SFD_BYTE (default 0xD5), all with tx_k = 0.
- R5: tx_fifo_re rises in the cycle in which the last preamble octet is on tx_data. The FIFO output one cycle later is the first frame byte, and it appears on tx_data right after the SFD, two cycles after the rise.
- R6: Each FIFO byte read during the frame appears on tx_data in order with tx_k = 0, whatever its value, including 0xBC and 0x50.
- R7: The byte that arrives together with tx_last_byte = 1 or tx_fifo_empty = 1 is the final frame byte. tx_fifo_re is still 1 in that cycle and is 0 in the following cycle.
- R8: Right after the final byte, tx_data shows 0xFD with tx_k = 1 and then 0xF7 with tx_k = 1.
- R9: If that 0xF7 falls on an even position (S at position 0, so this happens when PRE_LEN + N + 3 is even for N frame bytes), one more 0xF7 (tx_k = 1) follows. Every 0xBC then falls on an even position, and there are never three 0xF7 in a row.
- R10: A tx_start received while a frame is being sent is served after that frame, with at least one full idle pair between the last 0xF7 and the next 0xFB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-group clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | One-cycle request to send the frame held in the FIFO |
| fifo_d | input | CG_W (8) | FIFO read data, valid one cycle after tx_fifo_re |
| tx_fifo_empty | input | 1 | FIFO empty flag, arrives together with fifo_d |
| tx_last_byte | input | 1 | Marks the byte on fifo_d as the final byte of the frame |
| tx_fifo_re | output | 1 | FIFO read strobe |
| tx_data | output | CG_W (8) | Registered code-group octet |
| tx_k | output | 1 | 1 when tx_data is a control character |

## Verification
The hardest situation to reach is the frame boundary under load. In it, the stream needs the second carrier-extend character, a start request is already waiting, and the speculative read after the last byte must not take any of the next frame's bytes. The stimulus queues frames of odd and even length, so both the single and the doubled extend endings occur. It also issues a second start pulse a few cycles after the first, so the second request arrives during the first frame. The FIFO model in the bench discards the read that follows a flagged last byte, as a real frame-aware FIFO would. One frame ends on the empty flag alone, and some frames carry the idle octet values as data.

// File: rtl/sgx_pkg.sv
package sgx_pkg;

   typedef enum logic [3:0] {
      ST_IDLE_K,
      ST_IDLE_D,
      ST_SOP,
      ST_PRE,
      ST_SFD,
      ST_DATA,
      ST_EPD_T,
      ST_EPD_R,
      ST_EPD_R2
   } sgx_state_e;

   localparam logic [7:0] CG_COMMA  = 8'hBC;
   localparam logic [7:0] CG_IDLE_D = 8'h50;
   localparam logic [7:0] CG_SOP    = 8'hFB;
   localparam logic [7:0] CG_TERM   = 8'hFD;
   localparam logic [7:0] CG_EXT    = 8'hF7;

endpackage

// File: rtl/sgx_start_arm.sv
module sgx_start_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic consume_i,
   output logic armed_o
);
   logic armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= start_i | (armed_q & ~consume_i);
   end

   assign armed_o = armed_q;
endmodule

// File: rtl/sgx_lane_parity.sv
module sgx_lane_parity (
   input  logic clk,
   input  logic rst_n,
   input  logic realign_i,
   output logic odd_o
);
   // odd_q is the parity of the position of the code group loaded next
   logic odd_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         odd_q <= 1'b1;
      else if (realign_i) odd_q <= 1'b1;
      else                odd_q <= ~odd_q;
   end

   assign odd_o = odd_q;
endmodule

// File: rtl/sgx_pre_count.sv
module sgx_pre_count #(
   parameter int PRE_LEN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic step_i,
   output logic last_o
);
   localparam int CW = (PRE_LEN < 2) ? 1 : $clog2(PRE_LEN + 1);

   generate
      if (PRE_LEN < 1) begin : g_bad
         $error("sgx_pre_count: PRE_LEN must be at least 1");
      end
      if (PRE_LEN == 1) begin : g_single
         assign last_o = 1'b1;
      end else begin : g_multi
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      cnt_q <= '0;
            else if (load_i) cnt_q <= CW'(PRE_LEN);
            else if (step_i) cnt_q <= cnt_q - CW'(1);
         end
         assign last_o = (cnt_q == CW'(1));
      end
   endgenerate
endmodule

// File: rtl/sgx_seq_fsm.sv
module sgx_seq_fsm
   import sgx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       armed_i,
   input  logic       pre_last_i,
   input  logic       end_i,
   input  logic       odd_i,
   output sgx_state_e state_o,
   output logic       consume_o,
   output logic       rd_o,
   output logic       realign_o,
   output logic       pre_load_o,
   output logic       pre_step_o
);
   sgx_state_e st_q, st_n;

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE_D;
      else        st_q <= st_n;
   end

   always_comb begin
      st_n = st_q;
      unique case (st_q)
         ST_IDLE_K: st_n = ST_IDLE_D;
         ST_IDLE_D: st_n = armed_i ? ST_SOP : ST_IDLE_K;
         ST_SOP:    st_n = ST_PRE;
         ST_PRE:    st_n = pre_last_i ? ST_SFD : ST_PRE;
         ST_SFD:    st_n = ST_DATA;
         ST_DATA:   st_n = end_i ? ST_EPD_T : ST_DATA;
         ST_EPD_T:  st_n = ST_EPD_R;
         ST_EPD_R:  st_n = odd_i ? ST_IDLE_K : ST_EPD_R2;
         ST_EPD_R2: st_n = ST_IDLE_K;
         default:   st_n = ST_IDLE_K;
      endcase
   end

   assign state_o    = st_q;
   assign consume_o  = (st_q == ST_IDLE_D) && armed_i;
   assign rd_o       = (st_q == ST_SFD) || (st_q == ST_DATA);
   assign realign_o  = (st_q == ST_IDLE_K);
   assign pre_load_o = (st_q == ST_SOP);
   assign pre_step_o = (st_q == ST_PRE);
endmodule

// File: rtl/sgx_cg_mux.sv
module sgx_cg_mux
   import sgx_pkg::*;
#(
   parameter int         CG_W     = 8,
   parameter logic [7:0] PRE_BYTE = 8'h55,
   parameter logic [7:0] SFD_BYTE = 8'hD5
) (
   input  sgx_state_e      state_i,
   input  logic [CG_W-1:0] fifo_d_i,
   output logic [CG_W-1:0] cg_o,
   output logic            k_o
);
   always_comb begin
      cg_o = CG_COMMA;
      k_o  = 1'b1;
      unique case (state_i)
         ST_IDLE_K: begin cg_o = CG_COMMA;  k_o = 1'b1; end
         ST_IDLE_D: begin cg_o = CG_IDLE_D; k_o = 1'b0; end
         ST_SOP:    begin cg_o = CG_SOP;    k_o = 1'b1; end
         ST_PRE:    begin cg_o = PRE_BYTE;  k_o = 1'b0; end
         ST_SFD:    begin cg_o = SFD_BYTE;  k_o = 1'b0; end
         ST_DATA:   begin cg_o = fifo_d_i;  k_o = 1'b0; end
         ST_EPD_T:  begin cg_o = CG_TERM;   k_o = 1'b1; end
         ST_EPD_R,
         ST_EPD_R2: begin cg_o = CG_EXT;    k_o = 1'b1; end
         default:   begin cg_o = CG_COMMA;  k_o = 1'b1; end
      endcase
   end
endmodule

// File: rtl/sgx_tx_seq.sv
module sgx_tx_seq
   import sgx_pkg::*;
#(
   parameter int         CG_W     = 8,
   parameter int         PRE_LEN  = 6,
   parameter logic [7:0] PRE_BYTE = 8'h55,
   parameter logic [7:0] SFD_BYTE = 8'hD5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tx_start,
   input  logic [CG_W-1:0] fifo_d,
   input  logic            tx_fifo_empty,
   input  logic            tx_last_byte,
   output logic            tx_fifo_re,
   output logic [CG_W-1:0] tx_data,
   output logic            tx_k
);
   generate
      if (CG_W != 8) begin : g_bad_width
         $error("sgx_tx_seq: code groups are octets, CG_W must be 8");
      end
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("sgx_tx_seq: PRE_LEN must be at least 1");
      end
   endgenerate

   sgx_state_e      state;
   logic            armed, consume, rd, realign, odd;
   logic            pre_load, pre_step, pre_last;
   logic [CG_W-1:0] cg_n;
   logic            k_n;
   logic [CG_W-1:0] cg_q;
   logic            k_q;

   sgx_start_arm arm_i (
      .clk(clk), .rst_n(rst_n), .start_i(tx_start),
      .consume_i(consume), .armed_o(armed)
   );

   sgx_lane_parity par_i (
      .clk(clk), .rst_n(rst_n), .realign_i(realign), .odd_o(odd)
   );

   sgx_pre_count #(.PRE_LEN(PRE_LEN)) pre_i (
      .clk(clk), .rst_n(rst_n), .load_i(pre_load),
      .step_i(pre_step), .last_o(pre_last)
   );

   sgx_seq_fsm fsm_i (
      .clk(clk), .rst_n(rst_n), .armed_i(armed), .pre_last_i(pre_last),
      .end_i(tx_last_byte | tx_fifo_empty), .odd_i(odd),
      .state_o(state), .consume_o(consume), .rd_o(rd),
      .realign_o(realign), .pre_load_o(pre_load), .pre_step_o(pre_step)
   );

   sgx_cg_mux #(.CG_W(CG_W), .PRE_BYTE(PRE_BYTE), .SFD_BYTE(SFD_BYTE)) mux_i (
      .state_i(state), .fifo_d_i(fifo_d), .cg_o(cg_n), .k_o(k_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cg_q <= CG_COMMA;
         k_q  <= 1'b1;
      end else begin
         cg_q <= cg_n;
         k_q  <= k_n;
      end
   end

   assign tx_data    = cg_q;
   assign tx_k       = k_q;
   assign tx_fifo_re = rd;
endmodule

// File: rtl/sgx_tx_seq_chk.sv
module sgx_tx_seq_chk
   import sgx_pkg::*;
#(
   parameter int         CG_W     = 8,
   parameter logic [7:0] PRE_BYTE = 8'h55,
   parameter logic [7:0] SFD_BYTE = 8'hD5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tx_fifo_empty,
   input logic            tx_last_byte,
   input logic            tx_fifo_re,
   input logic [CG_W-1:0] tx_data,
   input logic            tx_k
);
   logic pos_odd;
   always_ff @(posedge clk) begin
      if (!rst_n) pos_odd <= 1'b0;
      else        pos_odd <= ~pos_odd;
   end

   wire is_bc  = tx_k && (tx_data == CG_COMMA);
   wire is_ext = tx_k && (tx_data == CG_EXT);

   p_idle_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_bc |=> (!tx_k && tx_data == CG_IDLE_D));

   p_sop_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_k && tx_data == CG_SOP) |-> !pos_odd);

   p_re_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_fifo_re) |-> (!tx_k && tx_data == PRE_BYTE) ##1 (!tx_k && tx_data == SFD_BYTE));

   p_re_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_fifo_re && (tx_last_byte || tx_fifo_empty)) |=> !tx_fifo_re);

   p_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_fifo_re && (tx_last_byte || tx_fifo_empty)) |=> ##1 (tx_k && tx_data == CG_TERM));

   p_ext_after_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_k && tx_data == CG_TERM) |=> is_ext);

   p_idle_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
      is_bc |-> !pos_odd);

   p_ext_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ext && $past(is_ext)) |=> is_bc);
endmodule

bind sgx_tx_seq sgx_tx_seq_chk #(.CG_W(CG_W), .PRE_BYTE(PRE_BYTE), .SFD_BYTE(SFD_BYTE)) chk_i (
   .clk(clk), .rst_n(rst_n), .tx_fifo_empty(tx_fifo_empty), .tx_last_byte(tx_last_byte),
   .tx_fifo_re(tx_fifo_re), .tx_data(tx_data), .tx_k(tx_k)
);

// File: tb/sgx_tx_seq_tb_top.sv
module sgx_tx_seq_tb_top;
   localparam int PRE_LEN = 6;

   typedef struct { logic k; logic [7:0] d; logic re; int req; } exp_t;
   typedef struct { logic [7:0] d; logic last; } fent_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_start = 1'b0;
   logic [7:0] fifo_d = 8'h00;
   logic       tx_fifo_empty = 1'b1;
   logic       tx_last_byte = 1'b0;
   logic       tx_fifo_re;
   logic [7:0] tx_data;
   logic       tx_k;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   finished = 0;
   exp_t  exp_q[$];
   fent_t fifo_q[$];

   always #10 clk = ~clk;

   sgx_tx_seq #(.PRE_LEN(PRE_LEN)) dut_i (
      .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .fifo_d(fifo_d),
      .tx_fifo_empty(tx_fifo_empty), .tx_last_byte(tx_last_byte),
      .tx_fifo_re(tx_fifo_re), .tx_data(tx_data), .tx_k(tx_k)
   );

   task automatic check(bit ok, int req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic push_exp(logic k, logic [7:0] d, logic re, int req);
      exp_t e;
      e.k = k; e.d = d; e.re = re; e.req = req;
      exp_q.push_back(e);
   endtask

   // driver: queue the frame into the FIFO model, push the expected stream, pulse start
   task automatic send_frame(int n, logic [7:0] seed, bit use_last);
      fent_t f;
      push_exp(1'b1, 8'hFB, 1'b0, 3);                      // R3 start-of-packet
      for (int p = 0; p < PRE_LEN; p++)
         push_exp(1'b0, 8'h55, p == PRE_LEN - 1, (p == PRE_LEN - 1) ? 5 : 4); // R4, R5
      push_exp(1'b0, 8'hD5, 1'b1, 4);                      // R4 SFD
      for (int i = 0; i < n; i++) begin
         f.d = seed + 8'(i * 8'h3B);
         f.last = use_last && (i == n - 1);
         fifo_q.push_back(f);
         push_exp(1'b0, f.d, i < n - 1, (i == n - 1) ? 7 : 6); // R6 data, R7 final byte
      end
      push_exp(1'b1, 8'hFD, 1'b0, 8);                      // R8 terminate
      push_exp(1'b1, 8'hF7, 1'b0, 8);                      // R8 extend
      if (((PRE_LEN + n + 3) % 2) == 0)
         push_exp(1'b1, 8'hF7, 1'b0, 9);                   // R9 extra extend
      @(negedge clk); tx_start = 1'b1;
      @(negedge clk); tx_start = 1'b0;
   endtask

   task automatic drain(int idle_cycles);
      while (exp_q.size() != 0) @(negedge clk);
      repeat (idle_cycles) @(negedge clk);
   endtask

   // FIFO model: one cycle read latency, the read after a flagged last byte is discarded
   initial begin
      bit rd_pend = 0;
      bit gate = 0;
      fent_t f;
      forever begin
         @(negedge clk);
         if (rd_pend) begin
            if (gate) begin
               fifo_d = 8'hEE; tx_last_byte = 1'b0; gate = 0;
            end else if (fifo_q.size() > 0) begin
               f = fifo_q.pop_front();
               fifo_d = f.d; tx_last_byte = f.last; gate = f.last;
            end else begin
               fifo_d = 8'hEE; tx_last_byte = 1'b0;
            end
         end
         tx_fifo_empty = (fifo_q.size() == 0);
         rd_pend = tx_fifo_re;
      end
   end

   // monitor / scoreboard
   initial begin
      bit pos = 0;
      bit prev_bc = 0;
      bit saw_idle = 1;
      bit idle_ok;
      exp_t e;
      @(posedge rst_n);
      forever begin
         idle_ok = (exp_q.size() == 0) || (exp_q[0].k && exp_q[0].d == 8'hFB);
         if (idle_ok && tx_k && tx_data == 8'hBC) begin
            check(pos == 0, 9, "idle comma on even position", int'(pos), 0);
            check(tx_fifo_re == 1'b0, 2, "no read while idle", int'(tx_fifo_re), 0);
            prev_bc = 1; saw_idle = 1;
         end else if (idle_ok && !tx_k && tx_data == 8'h50) begin
            check(prev_bc, 2, "idle data follows comma", int'(prev_bc), 1);
            prev_bc = 0;
         end else begin
            prev_bc = 0;
            if (exp_q.size() == 0) begin
               check(1'b0, 2, "unexpected code group", {tx_fifo_re, tx_k, tx_data}, 10'h1BC);
            end else begin
               e = exp_q.pop_front();
               if (e.k && e.d == 8'hFB) begin
                  check(pos == 0, 3, "frame start on even position", int'(pos), 0);
                  check(saw_idle, 10, "idle pair before frame", int'(saw_idle), 1);
                  saw_idle = 0;
               end
               check(tx_k == e.k && tx_data == e.d && tx_fifo_re == e.re, e.req,
                     "stream {re,k,data}", {tx_fifo_re, tx_k, tx_data}, {e.re, e.k, e.d});
            end
         end
         pos = ~pos;
         @(negedge clk);
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(tx_data == 8'hBC && tx_k == 1'b1, 1, "reset code group", {tx_k, tx_data}, 9'h1BC);
      check(tx_fifo_re == 1'b0, 1, "reset read strobe", int'(tx_fifo_re), 0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      send_frame(1, 8'h11, 1'b1);     // odd length: extra extend (R9)
      drain(3);
      send_frame(2, 8'h50, 1'b1);     // even length, idle data value as payload (R6)
      drain(4);
      send_frame(7, 8'hBC, 1'b1);     // odd, comma value as payload
      drain(5);
      send_frame(8, 8'h3C, 1'b1);     // even
      drain(2);
      send_frame(3, 8'hA0, 1'b1);     // back-to-back pair (R10)
      repeat (5) @(negedge clk);
      send_frame(4, 8'h07, 1'b1);
      drain(4);
      send_frame(5, 8'h62, 1'b0);     // ends on empty flag only (R7)
      drain(6);
      summary();
   end
endmodule